// File: doc/BRIEF.md
# Bus Master Cycle Sequencer with Retry Handling

This block is the bus-master side of a 32-bit processor's external bus. It takes one transfer request at a time and runs it on the bus. A request is either a single cycle or a line of four long words. A line can run as one burst, or with bursting inhibited, in which case it runs as four separate long-word cycles. Each bus cycle opens with a one-clock start pulse. A transfer-in-progress flag stays high from the first start pulse until the transfer ends.

The slave ends each data phase with one of three outcomes: acknowledge, error, or retry. A retry on the first cycle of a transfer reruns that cycle. If bus grant is negated together with the retry, the master first lets go of the bus and reruns the cycle once it is granted again. A retry on a later cycle of a line is not rerun. What happens instead depends on the acknowledge-mode input. A locked cycle that loses the bus while the relock input is high abandons the rest of its locked sequence. Each request ends with a single response beat that carries a status and an address.

Top module: `bus_retry_master`

## Requirements
- R1: While reset is held and right after it, `ts_o`, `tip_o` and `resp_valid_o` are low.
- R2: A request is taken only in idle with `bus_grant_i` high. `ts_o` pulses in the clock after acceptance. `tip_o` stays high until the response. An acknowledge on a single cycle gives `resp_status_o`=0 (OK) and `resp_addr_o` equal to the request address.
- R3: The termination code is: `term_ack_i` alone is a normal acknowledge, `term_err_i` alone is a bus error, and both high in the same clock is a retry. A bus error gives `resp_status_o`=1, and `resp_addr_o` is the address of the failing cycle.
- R4: A retry on the first cycle of any transfer, with grant still high, reruns that cycle at the same address. The new `ts_o` pulse comes in the clock after the retry.
- R5: A burst line gives one `ts_o` and takes four acknowledges. `addr_o` rises by 4 after each acknowledge and wraps inside the 16-byte line (bits 3:2 count up, the other bits hold).
- R6: A burst-inhibited line runs four cycles, each with its own `ts_o`, at the same wrapping addresses. `tip_o` stays high from the first cycle through the last.
- R7: With `ack_mode_i`=0 (compatibility), a retry on the 2nd, 3rd or 4th cycle of a line ends the transfer as a bus error at that cycle's address.
- R8: With `ack_mode_i`=1 (native), a retry on the 2nd, 3rd or 4th cycle of a line counts as an acknowledge.
- R9: A bus error on any cycle of a line ends the whole line at once, and no further cycles are started.
- R10: A first-cycle retry that comes with `bus_grant_i` low makes the master stop driving. `drive_o` and `tip_o` stay low until grant returns, and then the same cycle is rerun. In idle, `drive_o` follows `bus_grant_i`.
- R11: A locked cycle that is retried with grant low and `relock_i` high ends with `resp_status_o`=2 (abort). It is not rerun, and `lock_o` drops.
- R12: A locked cycle that is retried with grant low and `relock_i` low is rerun after grant returns, and it completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Start a transfer (taken in idle with grant) |
| req_addr_i | input | 32 | Start address |
| req_write_i | input | 1 | Write direction |
| req_size_i | input | 2 | Transfer size code, passed through to the bus |
| req_line_i | input | 1 | Four-long-word line transfer |
| req_noburst_i | input | 1 | Run line as separate cycles |
| req_lock_i | input | 1 | Cycle belongs to a locked sequence |
| ack_mode_i | input | 1 | 0 compatibility, 1 native |
| bus_grant_i | input | 1 | Bus grant |
| relock_i | input | 1 | Abort the locked sequence on relinquish |
| term_ack_i | input | 1 | Acknowledge termination |
| term_err_i | input | 1 | Error termination |
| ts_o | output | 1 | Cycle start pulse |
| tip_o | output | 1 | Transfer in progress |
| drive_o | output | 1 | Master drives the bus |
| addr_o | output | 32 | Current cycle address |
| write_o | output | 1 | Current direction |
| size_o | output | 2 | Current size code |
| burst_o | output | 1 | Current transfer is a burst line |
| lock_o | output | 1 | Locked cycle on the bus |
| resp_valid_o | output | 1 | One-clock response |
| resp_status_o | output | 2 | 0 OK, 1 bus error, 2 abort |
| resp_addr_o | output | 32 | Request address, or failing address |

## Verification
Every result sits one register behind its cause. The start pulse appears in the clock after acceptance, or after a first-cycle retry with grant held. The response appears in the clock after the terminating edge. After a retry that comes with grant low, the bus is released in the very next clock. The scripted slave drives each termination half a clock before the edge that consumes it and samples the outputs half a clock after that edge. As a result, each start pulse, response or release is checked exactly in the clock where it becomes due.

// File: rtl/bmrt_pkg.sv
package bmrt_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_WAIT  = 3'd2,
    S_RELQ  = 3'd3,
    S_YIELD = 3'd4
  } st_t;

  typedef enum logic [1:0] {
    T_NONE  = 2'd0,
    T_ACK   = 2'd1,
    T_ERR   = 2'd2,
    T_RETRY = 2'd3
  } term_t;

  typedef enum logic [1:0] {
    RS_OK    = 2'd0,
    RS_BERR  = 2'd1,
    RS_ABORT = 2'd2
  } rstat_t;
endpackage

// File: rtl/bmrt_term_dec.sv
module bmrt_term_dec
  import bmrt_pkg::*;
(
  input  logic  ack_i,
  input  logic  err_i,
  output term_t term_o
);
  always_comb begin
    unique case ({err_i, ack_i})
      2'b01:   term_o = T_ACK;
      2'b10:   term_o = T_ERR;
      2'b11:   term_o = T_RETRY;
      default: term_o = T_NONE;
    endcase
  end
endmodule

// File: rtl/bmrt_addr_seq.sv
module bmrt_addr_seq #(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_nxt_o
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam int OFF_W  = $clog2(BEAT_BYTES);
  localparam int LINE_W = BEAT_W + OFF_W;
  localparam logic [BEAT_W-1:0] STEP = BEAT_W'(1);

  logic [BEAT_W-1:0] idx_nxt;
  assign idx_nxt = addr_i[LINE_W-1:OFF_W] + STEP;

  generate
    if (OFF_W > 0) begin : g_off
      assign addr_nxt_o = {addr_i[ADDR_W-1:LINE_W], idx_nxt, addr_i[OFF_W-1:0]};
    end else begin : g_nooff
      assign addr_nxt_o = {addr_i[ADDR_W-1:LINE_W], idx_nxt};
    end
  endgenerate
endmodule

// File: rtl/bmrt_beat_ctr.sv
module bmrt_beat_ctr #(
  parameter int BEATS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_i,
  input  logic                      inc_i,
  output logic [$clog2(BEATS)-1:0]  beat_o,
  output logic                      last_o
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] beat_d, beat_q;
  logic              beat_en;

  assign beat_en = clr_i | inc_i;

  always_comb begin
    if (clr_i) beat_d = '0;
    else       beat_d = beat_q + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  assign beat_o = beat_q;
  assign last_o = (beat_q == LAST);
endmodule

// File: rtl/bus_retry_master.sv
module bus_retry_master
  import bmrt_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BEATS      = 4,
  parameter int BEAT_BYTES = 4,
  parameter int SIZE_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [SIZE_W-1:0] req_size_i,
  input  logic              req_line_i,
  input  logic              req_noburst_i,
  input  logic              req_lock_i,
  input  logic              ack_mode_i,
  input  logic              bus_grant_i,
  input  logic              relock_i,
  input  logic              term_ack_i,
  input  logic              term_err_i,
  output logic              ts_o,
  output logic              tip_o,
  output logic              drive_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              write_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              burst_o,
  output logic              lock_o,
  output logic              resp_valid_o,
  output logic [1:0]        resp_status_o,
  output logic [ADDR_W-1:0] resp_addr_o
);
  localparam int BEAT_W = $clog2(BEATS);

  st_t               st_q, st_d;
  term_t             term;
  logic [BEAT_W-1:0] beat;
  logic              beat_last;
  logic [ADDR_W-1:0] addr_q, start_q, addr_nxt;
  logic              write_q, line_q, nob_q, lock_q;
  logic [SIZE_W-1:0] size_q;
  logic              accept, beat_clr, beat_inc, addr_adv;
  logic              follow_on, treat_ack, treat_err;
  logic              rsp_set, rsp_valid_q;
  rstat_t            rsp_stat_d, rsp_stat_q;
  logic [ADDR_W-1:0] rsp_addr_d, rsp_addr_q;

  bmrt_term_dec u_term (
    .ack_i  (term_ack_i),
    .err_i  (term_err_i),
    .term_o (term)
  );

  bmrt_addr_seq #(
    .ADDR_W     (ADDR_W),
    .BEATS      (BEATS),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_aseq (
    .addr_i     (addr_q),
    .addr_nxt_o (addr_nxt)
  );

  bmrt_beat_ctr #(.BEATS(BEATS)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (beat_clr),
    .inc_i  (beat_inc),
    .beat_o (beat),
    .last_o (beat_last)
  );

  // Later cycles of a line are part of the first one and are never rerun.
  assign follow_on = line_q && (beat != '0);

  always_comb begin
    treat_ack = 1'b0;
    treat_err = 1'b0;
    if (st_q == S_WAIT) begin
      case (term)
        T_ACK:   treat_ack = 1'b1;
        T_ERR:   treat_err = 1'b1;
        T_RETRY: begin
          if (follow_on) begin
            treat_ack = ack_mode_i;
            treat_err = !ack_mode_i;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    st_d       = st_q;
    accept     = 1'b0;
    beat_clr   = 1'b0;
    beat_inc   = 1'b0;
    addr_adv   = 1'b0;
    rsp_set    = 1'b0;
    rsp_stat_d = RS_OK;
    rsp_addr_d = start_q;
    case (st_q)
      S_IDLE: begin
        if (req_valid_i && bus_grant_i) begin
          accept   = 1'b1;
          beat_clr = 1'b1;
          st_d     = S_START;
        end
      end
      S_START: st_d = S_WAIT;
      S_WAIT: begin
        if (treat_err) begin
          rsp_set    = 1'b1;
          rsp_stat_d = RS_BERR;
          rsp_addr_d = addr_q;
          st_d       = S_IDLE;
        end else if (treat_ack) begin
          if (!line_q || beat_last) begin
            rsp_set = 1'b1;
            st_d    = S_IDLE;
          end else begin
            beat_inc = 1'b1;
            addr_adv = 1'b1;
            st_d     = nob_q ? S_START : S_WAIT;
          end
        end else if (term == T_RETRY) begin
          if (bus_grant_i) begin
            st_d = S_START;
          end else if (lock_q && relock_i) begin
            rsp_set    = 1'b1;
            rsp_stat_d = RS_ABORT;
            st_d       = S_YIELD;
          end else begin
            st_d = S_RELQ;
          end
        end
      end
      S_RELQ:  if (bus_grant_i) st_d = S_START;
      S_YIELD: if (bus_grant_i) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      write_q <= 1'b0;
      size_q  <= '0;
      line_q  <= 1'b0;
      nob_q   <= 1'b0;
      lock_q  <= 1'b0;
    end else if (accept) begin
      start_q <= req_addr_i;
      write_q <= req_write_i;
      size_q  <= req_size_i;
      line_q  <= req_line_i;
      nob_q   <= req_noburst_i;
      lock_q  <= req_lock_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_q <= '0;
    else if (accept)   addr_q <= req_addr_i;
    else if (addr_adv) addr_q <= addr_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid_q <= 1'b0;
    else        rsp_valid_q <= rsp_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_stat_q <= RS_OK;
      rsp_addr_q <= '0;
    end else if (rsp_set) begin
      rsp_stat_q <= rsp_stat_d;
      rsp_addr_q <= rsp_addr_d;
    end
  end

  assign ts_o          = (st_q == S_START);
  assign tip_o         = (st_q == S_START) || (st_q == S_WAIT);
  assign drive_o       = (st_q == S_IDLE) ? bus_grant_i
                                          : !((st_q == S_RELQ) || (st_q == S_YIELD));
  assign addr_o        = addr_q;
  assign write_o       = write_q;
  assign size_o        = size_q;
  assign burst_o       = line_q && !nob_q;
  assign lock_o        = lock_q && tip_o;
  assign resp_valid_o  = rsp_valid_q;
  assign resp_status_o = rsp_stat_q;
  assign resp_addr_o   = rsp_addr_q;
endmodule

// File: rtl/bus_retry_master_chk.sv
module bus_retry_master_chk
  import bmrt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ts_o,
  input logic              tip_o,
  input logic              drive_o,
  input logic              lock_o,
  input logic              resp_valid_o,
  input logic [1:0]        resp_status_o,
  input logic [ADDR_W-1:0] resp_addr_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              bus_grant_i,
  input logic              term_ack_i,
  input logic              term_err_i,
  input logic              ack_mode_i,
  input st_t               st_q,
  input logic [BEAT_W-1:0] beat
);
  logic in_wait;
  assign in_wait = (st_q == S_WAIT);

  a_r2_ts_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ts_o |=> !ts_o);

  a_r6_ts_inside_tip: assert property (@(posedge clk) disable iff (!rst_n)
    ts_o |-> tip_o);

  a_r10_tip_only_driven: assert property (@(posedge clk) disable iff (!rst_n)
    tip_o |-> drive_o);

  a_r3_err_reports: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && term_err_i && !term_ack_i)
      |=> (resp_valid_o && resp_status_o == 2'd1 && resp_addr_o == $past(addr_o)));

  a_r4_rerun_same: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && term_err_i && term_ack_i && beat == '0 && bus_grant_i)
      |=> (ts_o && $stable(addr_o)));

  a_r7_compat_berr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && term_err_i && term_ack_i && beat != '0 && !ack_mode_i)
      |=> (resp_valid_o && resp_status_o == 2'd1));

  a_r8_native_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && term_err_i && term_ack_i && beat != '0 && ack_mode_i)
      |=> !(resp_valid_o && resp_status_o == 2'd1));

  a_r11_lock_in_tip: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |-> tip_o);

  a_r2_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid_o |=> !resp_valid_o);
endmodule

bind bus_retry_master bus_retry_master_chk #(
  .ADDR_W (ADDR_W),
  .BEAT_W (BEAT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ts_o          (ts_o),
  .tip_o         (tip_o),
  .drive_o       (drive_o),
  .lock_o        (lock_o),
  .resp_valid_o  (resp_valid_o),
  .resp_status_o (resp_status_o),
  .resp_addr_o   (resp_addr_o),
  .addr_o        (addr_o),
  .bus_grant_i   (bus_grant_i),
  .term_ack_i    (term_ack_i),
  .term_err_i    (term_err_i),
  .ack_mode_i    (ack_mode_i),
  .st_q          (st_q),
  .beat          (beat)
);

// File: tb/bus_retry_master_tb.sv
`timescale 1ns/1ps
module bus_retry_master_tb_top;
  typedef struct packed {
    logic        line;
    logic        nob;
    logic        lock;
    logic        mode;
    logic        relock;
    logic [2:0]  nt;
    logic [11:0] terms;
    logic [2:0]  drop;
    logic [1:0]  st;
    logic [2:0]  nts;
    logic [3:0]  off;
  } vec_t;

  localparam int NV = 17;
  // term codes: 0 none, 1 ack, 2 err, 3 retry; drop 7 = grant held
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd1,12'h001,3'd7,2'd0,3'd1,4'hC}, // R2
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,12'h004,3'd7,2'd0,3'd1,4'hC}, // R2 wait state
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd1,12'h002,3'd7,2'd1,3'd1,4'hC}, // R3
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,12'h007,3'd7,2'd0,3'd2,4'hC}, // R4
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd4,12'h055,3'd7,2'd0,3'd1,4'hC}, // R5
    '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd4,12'h055,3'd7,2'd0,3'd4,4'hC}, // R6
    '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd2,12'h00D,3'd7,2'd1,3'd2,4'h0}, // R7
    '{1'b1,1'b1,1'b0,1'b1,1'b0,3'd4,12'h05D,3'd7,2'd0,3'd4,4'hC}, // R8
    '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd5,12'h157,3'd7,2'd0,3'd5,4'hC}, // R4 line
    '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd3,12'h025,3'd7,2'd1,3'd3,4'h4}, // R9
    '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd2,12'h007,3'd0,2'd0,3'd2,4'hC}, // R10
    '{1'b0,1'b0,1'b1,1'b0,1'b1,3'd1,12'h003,3'd0,2'd2,3'd1,4'hC}, // R11
    '{1'b0,1'b0,1'b1,1'b0,1'b0,3'd2,12'h007,3'd0,2'd0,3'd2,4'hC}, // R12
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd3,12'h025,3'd7,2'd1,3'd1,4'h4}, // R9 burst
    '{1'b1,1'b0,1'b0,1'b1,1'b0,3'd4,12'h05D,3'd7,2'd0,3'd1,4'hC}, // R8 burst
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd2,12'h00D,3'd7,2'd1,3'd1,4'h0}, // R7 burst
    '{1'b1,1'b0,1'b0,1'b0,1'b0,3'd5,12'h157,3'd7,2'd0,3'd2,4'hC}  // R4 burst
  };

  logic        clk, rst_n;
  logic        req_valid, req_write, req_line, req_nob, req_lock, ack_mode;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        grant, relock, t_ack, t_err;
  logic        ts, tip, drive, wr, burst, lock, rv;
  logic [31:0] addr, raddr;
  logic [1:0]  size, rstat;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  bus_retry_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_size_i(req_size), .req_line_i(req_line),
    .req_noburst_i(req_nob), .req_lock_i(req_lock), .ack_mode_i(ack_mode),
    .bus_grant_i(grant), .relock_i(relock), .term_ack_i(t_ack), .term_err_i(t_err),
    .ts_o(ts), .tip_o(tip), .drive_o(drive), .addr_o(addr), .write_o(wr),
    .size_o(size), .burst_o(burst), .lock_o(lock), .resp_valid_o(rv),
    .resp_status_o(rstat), .resp_addr_o(raddr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 1: return "R2";
      2: return "R3";
      3, 8, 16: return "R4";
      4: return "R5";
      5: return "R6";
      6, 15: return "R7";
      7, 14: return "R8";
      9, 13: return "R9";
      10: return "R10";
      11: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] line_addr(input logic [31:0] a, input int n);
    logic [1:0] idx;
    idx = a[3:2] + 2'(n);
    return {a[31:4], idx, a[1:0]};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_write = 0; req_line = 0; req_nob = 0;
    req_lock = 0; ack_mode = 0; req_addr = '0; req_size = 2'd2;
    grant = 1'b1; relock = 0; t_ack = 0; t_err = 0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    chk(!ts && !tip && !rv, "R1", "outputs in reset", {29'd0, ts, tip, rv}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ts && !tip && !rv, "R1", "outputs after reset", {29'd0, ts, tip, rv}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VEC[i];
      automatic logic [31:0] a = 32'h4000_000C | (32'(i) << 8);
      automatic int k = 0, nts = 0, nacks = 0, gl = 0, it = 0;
      automatic bit seen = 0, dropped = 0, want_ts = 0;
      automatic logic [1:0] gst = 2'd3;
      automatic logic [31:0] gaddr = '0;
      automatic string tg = vtag(i);

      req_addr = a; req_line = v.line; req_nob = v.nob; req_lock = v.lock;
      ack_mode = v.mode; req_write = i[0]; req_valid = 1'b1; grant = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      while (!(seen && gl == 0) && it < 60) begin
        it++;
        if (rv) begin seen = 1; gst = rstat; gaddr = raddr; end
        if (want_ts)
          chk(ts, "R4", "start pulse one clock after retry", {31'd0, ts}, 32'd1);
        want_ts = 0;
        if (ts) begin
          nts++;
          chk(addr == line_addr(a, nacks), v.nob ? "R6" : "R2", "cycle address",
              addr, line_addr(a, nacks));
        end
        if (!seen && !dropped)
          chk(tip, v.line ? "R6" : "R2", "tip held during transfer", {31'd0, tip}, 32'd1);
        relock = 1'b0;
        if (gl > 0) begin
          chk(!drive && !tip, "R10", "bus released", {30'd0, drive, tip}, 32'd0);
          gl--;
          if (gl == 0) grant = 1'b1;
        end
        t_ack = 1'b0; t_err = 1'b0;
        if (tip && !ts && k < int'(v.nt)) begin
          automatic logic [1:0] c = v.terms[2*k +: 2];
          chk(addr == line_addr(a, nacks), "R5", "address at termination",
              addr, line_addr(a, nacks));
          t_ack = c[0]; t_err = c[1];
          if (c == 2'd1) nacks++;
          if (c == 2'd3 && k > 0 && v.mode) nacks++;
          if (c == 2'd3 && nacks == 0 && 32'(k) != 32'(v.drop)) want_ts = 1;
          if (32'(k) == 32'(v.drop)) begin
            grant = 1'b0; relock = v.relock; gl = 3; dropped = 1;
          end
          k++;
        end
        @(negedge clk);
      end
      t_ack = 0; t_err = 0; relock = 0; grant = 1'b1;
      chk(seen && gst == v.st, tg, "response status", {30'd0, gst}, {30'd0, v.st});
      chk(gaddr == {a[31:4], v.off}, tg, "response address", gaddr, {a[31:4], v.off});
      chk(nts == int'(v.nts), tg, "start pulse count", 32'(nts), 32'(v.nts));
      @(negedge clk);
    end

    // R10: idle drive follows grant
    grant = 1'b0;
    @(negedge clk);
    chk(!drive, "R10", "idle without grant not driving", {31'd0, drive}, 32'd0);
    // R2: request ignored without grant
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!ts && !tip, "R2", "request ignored without grant", {30'd0, ts, tip}, 32'd0);
    grant = 1'b1;
    @(negedge clk);
    chk(drive && !tip, "R10", "idle with grant driving", {30'd0, drive, tip}, 32'd2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule